// File: doc/BRIEF.md
# Camera Capture Status Register

This block collects the status of a camera capture interface into one 32-bit word that a simple register read port can fetch. Two kinds of bit live in the word. Event bits are sticky: a single-cycle pulse from the datapath sets them, and a read clears them. Level bits show the live state of an internal condition at the moment of the read. The FIFOs, DMA channels, sync decoder and CRC checker that produce these indications are not part of the block. They appear only as pulse and level inputs.

Several event bits are set only under a qualifying condition. A FIFO overflow counts only when a write meets a full FIFO. A sync-code CRC error counts only when embedded-sync correction is enabled and the error was not corrected. A frame-rate overrun counts only when a vertical sync arrives while a flush is in progress. The block also drives three side outputs. One pulse discards the frame after a CRC error. One level skips the current frame after an overrun. One pulse applies a channel-status change, and it is held back while clock-domain synchronisation is busy.

Top module: `cap_status_reg`

## Requirements
- R1: After reset, `rd_data`, `frame_drop`, `skip_frame` and `chan_apply` are 0, and every sticky bit is 0.
- R2: Level bits reflect their inputs at the read edge: bit 0 = `mod_en`, bit 8 = `codec_pend`, bit 19 = `sync_busy`. Bit positions 3-7, 9, 11-15, 18, 20-23 and 28-31 always read 0.
- R3: A one-cycle pulse sets its sticky bit: bit 1 = `dis_done_p`, bit 2 = `srst_done_p`, bit 10 = `vsync_p`, bit 16 = `prev_done_p`, bit 17 = `codec_done_p`.
- R4: A read (`rd_en` high at a clock edge) clears every sticky bit at that same edge, unless a new event arrives in that cycle. A later read then returns the bit as 0.
- R5: If an event pulse and a read share a cycle, the read returns the value from before the event, and the bit stays set for the next read.
- R6: Bit 24 is set by `prev_wr_p` while `prev_full` is high, and bit 25 by `codec_wr_p` while `codec_full` is high. A write to a FIFO that is not full sets nothing.
- R7: Bit 26 is set by `crc_err_p` only when `sync_fix_en` is high and `crc_fixed` is low. On that event, `frame_drop` pulses high for exactly the next cycle.
- R8: Bit 27 is set when `vsync_p` occurs with `flush_busy` high. `skip_frame` goes high the cycle after that event and stays high until a `vsync_p` arrives with `flush_busy` low.
- R9: `chan_apply` pulses the cycle after `chan_req` only if `sync_busy` was low. A request made while `sync_busy` is high is dropped.
- R10: `rd_data` is loaded only at an edge where `rd_en` is high. It holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Status word captured by the last read |
| mod_en | input | 1 | Module-enabled level |
| dis_done_p | input | 1 | Disable request finished (pulse) |
| srst_done_p | input | 1 | Software reset finished (pulse) |
| codec_pend | input | 1 | Codec request deferred to next frame (level) |
| vsync_p | input | 1 | Vertical sync detected (pulse) |
| prev_done_p | input | 1 | Preview transfer finished (pulse) |
| codec_done_p | input | 1 | Codec transfer finished (pulse) |
| sync_busy | input | 1 | Clock-domain synchronisation in progress (level) |
| prev_wr_p | input | 1 | Write attempt into preview FIFO |
| prev_full | input | 1 | Preview FIFO full |
| codec_wr_p | input | 1 | Write attempt into codec FIFO |
| codec_full | input | 1 | Codec FIFO full |
| crc_err_p | input | 1 | Sync-code CRC error detected (pulse) |
| crc_fixed | input | 1 | That error was corrected |
| sync_fix_en | input | 1 | Embedded-sync correction enabled |
| flush_busy | input | 1 | FIFO flush in progress |
| chan_req | input | 1 | Request to change channel status |
| chan_apply | output | 1 | Channel-status change applied |
| frame_drop | output | 1 | Discard-frame pulse |
| skip_frame | output | 1 | Current frame is being skipped |

## Verification
Every result is due exactly one clock edge after its stimulus. `rd_data`, the sticky bits, `frame_drop`, `skip_frame` and `chan_apply` all change at the edge that samples their inputs. The bench drives inputs at the falling edge and advances its reference model once per rising edge. It then compares every output at the following falling edge, so each comparison sees the value produced by the edge just passed. The shared-cycle read and event case is checked over two consecutive reads: the first must not show the event, and the second must.

// File: rtl/cap_status_reg.sv
module cap_status_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  input  logic        mod_en,
  input  logic        dis_done_p,
  input  logic        srst_done_p,
  input  logic        codec_pend,
  input  logic        vsync_p,
  input  logic        prev_done_p,
  input  logic        codec_done_p,
  input  logic        sync_busy,
  input  logic        prev_wr_p,
  input  logic        prev_full,
  input  logic        codec_wr_p,
  input  logic        codec_full,
  input  logic        crc_err_p,
  input  logic        crc_fixed,
  input  logic        sync_fix_en,
  input  logic        flush_busy,
  input  logic        chan_req,
  output logic        chan_apply,
  output logic        frame_drop,
  output logic        skip_frame
);
  localparam int B_EN = 0, B_DIS = 1, B_SRST = 2, B_CPND = 8, B_VS = 10;
  localparam int B_PDONE = 16, B_CDONE = 17, B_SYNC = 19;
  localparam int B_POVF = 24, B_COVF = 25, B_CRC = 26, B_FOVR = 27;
  localparam logic [31:0] USED = 32'h0F0B_0507;

  logic [31:0] sticky, ev, lvl, status;

  always_comb begin
    ev          = '0;
    ev[B_DIS]   = dis_done_p;
    ev[B_SRST]  = srst_done_p;
    ev[B_VS]    = vsync_p;
    ev[B_PDONE] = prev_done_p;
    ev[B_CDONE] = codec_done_p;
    ev[B_POVF]  = prev_wr_p & prev_full;
    ev[B_COVF]  = codec_wr_p & codec_full;
    ev[B_CRC]   = crc_err_p & sync_fix_en & ~crc_fixed;
    ev[B_FOVR]  = vsync_p & flush_busy;
  end

  always_comb begin
    lvl         = '0;
    lvl[B_EN]   = mod_en;
    lvl[B_CPND] = codec_pend;
    lvl[B_SYNC] = sync_busy;
  end

  assign status = sticky | lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky     <= '0;
      rd_data    <= '0;
      frame_drop <= 1'b0;
      skip_frame <= 1'b0;
      chan_apply <= 1'b0;
    end else begin
      sticky     <= (rd_en ? '0 : sticky) | ev;
      if (rd_en) rd_data <= status;
      frame_drop <= ev[B_CRC];
      if (vsync_p) skip_frame <= flush_busy;
      chan_apply <= chan_req & ~sync_busy;
    end
  end

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~USED) == 32'h0);
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !vsync_p) |=> !sticky[B_VS]);
  assert_event_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && vsync_p) |=> (sticky[B_VS] && !rd_data[B_VS]) || $past(sticky[B_VS]));
  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky[B_POVF]) |-> $past(prev_wr_p && prev_full));
  assert_crc_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> $past(sync_fix_en && !crc_fixed && crc_err_p));
  assert_skip_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(skip_frame) |-> $past(vsync_p && flush_busy));
  assert_chan_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_apply |-> !$past(sync_busy));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/cap_status_reg_tb.sv
`timescale 1ns/1ps
module cap_status_reg_tb;
  logic clk = 0, rst_n = 0, rd_en = 0;
  logic [31:0] rd_data;
  logic mod_en = 0, dis_done_p = 0, srst_done_p = 0, codec_pend = 0, vsync_p = 0;
  logic prev_done_p = 0, codec_done_p = 0, sync_busy = 0, prev_wr_p = 0, prev_full = 0;
  logic codec_wr_p = 0, codec_full = 0, crc_err_p = 0, crc_fixed = 0, sync_fix_en = 0;
  logic flush_busy = 0, chan_req = 0;
  logic chan_apply, frame_drop, skip_frame;

  int checks = 0, failures = 0;
  bit [31:0] m_st = 0, m_rd = 0;
  bit m_drop = 0, m_skip = 0, m_app = 0;

  always #2.5 clk = ~clk;

  cap_status_reg u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk(rd_data[0] == m_rd[0] && rd_data[8] == m_rd[8] && rd_data[19] == m_rd[19],
        "R2 level bits", rd_data, m_rd);
    chk((rd_data & 32'hF0F4_FAF8) == 0, "R2 unused bits", rd_data, 32'h0);
    chk((rd_data & 32'h0003_0406) == (m_rd & 32'h0003_0406), "R3/R4 sticky events", rd_data, m_rd);
    chk(rd_data[25:24] == m_rd[25:24], "R6 overflow bits", rd_data, m_rd);
    chk(rd_data[26] == m_rd[26], "R7 crc bit", rd_data, m_rd);
    chk(rd_data[27] == m_rd[27], "R8 overrun bit", rd_data, m_rd);
    chk(rd_data == m_rd, "R10 read word", rd_data, m_rd);
    chk(frame_drop == m_drop, "R7 frame_drop", frame_drop, m_drop);
    chk(skip_frame == m_skip, "R8 skip_frame", skip_frame, m_skip);
    chk(chan_apply == m_app, "R9 chan_apply", chan_apply, m_app);
  endtask

  task automatic step();
    bit [31:0] lv, ev;
    @(posedge clk);
    lv = 0; ev = 0;
    lv[0] = mod_en; lv[8] = codec_pend; lv[19] = sync_busy;
    ev[1] = dis_done_p; ev[2] = srst_done_p; ev[10] = vsync_p;
    ev[16] = prev_done_p; ev[17] = codec_done_p;
    ev[24] = prev_wr_p && prev_full; ev[25] = codec_wr_p && codec_full;
    ev[26] = crc_err_p && sync_fix_en && !crc_fixed;
    ev[27] = vsync_p && flush_busy;
    if (rd_en) m_rd = m_st | lv;
    m_st = (rd_en ? 32'h0 : m_st) | ev;
    m_drop = ev[26];
    if (vsync_p) m_skip = flush_busy;
    m_app = chan_req && !sync_busy;
    @(negedge clk);
    cmp_all();
  endtask

  task automatic quiet();
    {dis_done_p, srst_done_p, vsync_p, prev_done_p, codec_done_p, prev_wr_p,
     codec_wr_p, crc_err_p, chan_req, rd_en} = '0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(rd_data == 0 && !frame_drop && !skip_frame && !chan_apply, "R1 reset outputs",
        {rd_data[31:3], frame_drop, skip_frame, chan_apply}, 0);
    rd_en = 1;
    step();
    chk(rd_data == 0, "R1 first read after reset", rd_data, 0);
    for (int i = 0; i < 4000; i++) begin
      rd_en        = ($urandom_range(0, 4) == 0);
      mod_en       = $urandom_range(0, 1);
      codec_pend   = $urandom_range(0, 1);
      sync_busy    = $urandom_range(0, 1);
      dis_done_p   = ($urandom_range(0, 7) == 0);
      srst_done_p  = ($urandom_range(0, 7) == 0);
      vsync_p      = ($urandom_range(0, 9) == 0);
      prev_done_p  = ($urandom_range(0, 7) == 0);
      codec_done_p = ($urandom_range(0, 7) == 0);
      prev_wr_p    = $urandom_range(0, 1);
      prev_full    = ($urandom_range(0, 5) == 0);
      codec_wr_p   = $urandom_range(0, 1);
      codec_full   = ($urandom_range(0, 5) == 0);
      crc_err_p    = ($urandom_range(0, 5) == 0);
      crc_fixed    = $urandom_range(0, 1);
      sync_fix_en  = $urandom_range(0, 1);
      flush_busy   = $urandom_range(0, 1);
      chan_req     = $urandom_range(0, 2) == 0;
      step();
    end
    quiet();
    rd_en = 1; step();
    rd_en = 1; vsync_p = 1; flush_busy = 0; step();
    chk(rd_data[10] == 0, "R5 read shares cycle with event", rd_data[10], 0);
    quiet(); rd_en = 1; step();
    chk(rd_data[10] == 1, "R5 event kept for next read", rd_data[10], 1);
    quiet(); rd_en = 1; step();
    chk(rd_data[10] == 0, "R4 cleared after read", rd_data[10], 0);
    quiet(); prev_wr_p = 1; prev_full = 0; step();
    quiet(); rd_en = 1; step();
    chk(rd_data[24] == 0, "R6 write to non-full fifo ignored", rd_data[24], 0);
    quiet(); crc_err_p = 1; sync_fix_en = 0; crc_fixed = 0; step();
    chk(frame_drop == 0, "R7 crc ignored when disabled", frame_drop, 0);
    quiet(); rd_en = 1; step();
    chk(rd_data[26] == 0, "R7 crc bit stays clear when disabled", rd_data[26], 0);
    quiet(); held = rd_data; dis_done_p = 1; vsync_p = 1; flush_busy = 1; step();
    chk(rd_data == held, "R10 no read holds rd_data", rd_data, held);
    chk(skip_frame == 1, "R8 skip after overrun", skip_frame, 1);
    quiet(); flush_busy = 0; sync_busy = 1; chan_req = 1; step();
    chk(chan_apply == 0, "R9 request dropped while busy", chan_apply, 0);
    chk(skip_frame == 1, "R8 skip holds within frame", skip_frame, 1);
    quiet(); vsync_p = 1; step();
    chk(skip_frame == 0, "R8 skip ends at clean vsync", skip_frame, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule